// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Edge Latches

This block arbitrates the interrupt sources of a small 8-bit processor. Two external pins each feed a synchronizer and a falling-edge detector whose hit is held in a software-visible latch bit; eight peripheral sources each hold a pending bit that the peripheral sets with a pulse and clears with its flag-clear sequence. A software trap request, the interrupt mask bit and a low-power wait state complete the picture. Every cycle the block ranks all live requests, presents the vector address of the winner, and raises a take strobe when the processor may enter the handler.

The processor core reports instruction boundaries, trap execution, wait-for-interrupt execution and return-from-interrupt (with the mask bit recovered from the stacked condition byte). A 4-bit register port exposes the two edge enables and the two edge latches. A sequencer with three states orders the work: `ST_BOOT` (first cycle out of reset, reset vector fetch), `ST_RUN` (normal execution) and `ST_SLEEP` (processor clock gated). Transitions: boot_done (`ST_BOOT` to `ST_RUN`, always after one cycle), wfi_enter (`ST_RUN` to `ST_SLEEP` on a wait instruction that is not overtaken by an interrupt), wake_up (`ST_SLEEP` to `ST_RUN` as soon as any unmasked request exists).

Top module: `intc_core`

## Requirements
- R1: A falling edge on `ext_pin[0]` sets latch bit 2 of the register port, one on `ext_pin[1]` sets bit 3; the bit reads 1 at the third rising clock edge after the pin falls (two synchronizer stages, one detect stage). A rising edge sets nothing.
- R2: Register bits 0 and 1 are the enables for pin 0 and pin 1 and take the written value; writing 0 to latch bit 2 or 3 clears it, writing 1 leaves it unchanged, and a new edge in the same cycle wins over the clear.
- R3: An edge source requests service only while its latch bit and enable bit are both 1 and the mask is 0.
- R4: A `periph_set` pulse makes that source pending; it requests service only while `periph_en` for it is 1 and the mask is 0. A `periph_clr` pulse empties the pending bit (and wins over a set in the same cycle), so a request still waiting for its enable is lost.
- R5: In `ST_RUN`, `take_irq` rises only in a cycle with `insn_end` high.
- R6: `trap_req` at an instruction boundary is taken even while the mask is 1; its vector is FFEEh.
- R7: The winner, from highest: peripheral 0 FFFCh, peripheral 1 FFFAh, peripheral 2 FFF6h, trap FFEEh, peripheral 3 FFECh, peripheral 4 FFEAh, pin 1 FFE8h, pin 0 FFE6h, peripheral 5 FFE4h, peripheral 6 FFE2h, peripheral 7 FFE0h. With no request `vec_addr` is FFFEh.
- R8: The cycle after `take_irq`, `irq_mask` is 1.
- R9: `iret_exec` loads `irq_mask` with `stacked_i` at the next edge.
- R10: `wfi_exec` in `ST_RUN` clears the mask and drops `cpu_run` at the next edge; in `ST_SLEEP` any unmasked request raises `wake` and `take_irq` in the same cycle, and `cpu_run` returns one edge later.
- R11: After reset the mask is 1, `reg_rdata` is 0, `cpu_run` is 1, `take_irq` is 0, and `boot_fetch` is 1 for exactly the first cycle after reset release.
- R12: `mask_set` sets and `mask_clr` clears `irq_mask` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | External edge pins, asynchronous |
| periph_set | input | 8 | Peripheral pending set pulses |
| periph_clr | input | 8 | Peripheral flag-clear pulses |
| periph_en | input | 8 | Peripheral interrupt enables |
| trap_req | input | 1 | Trap instruction executing |
| insn_end | input | 1 | Instruction boundary |
| wfi_exec | input | 1 | Wait-for-interrupt instruction executing |
| iret_exec | input | 1 | Return-from-interrupt restores the mask |
| stacked_i | input | 1 | Mask bit from the stacked condition byte |
| mask_set | input | 1 | Software sets the mask |
| mask_clr | input | 1 | Software clears the mask |
| reg_we | input | 1 | Register port write strobe |
| reg_wdata | input | 4 | Register port write data |
| reg_rdata | output | 4 | Register port read data |
| take_irq | output | 1 | Enter the handler now |
| vec_addr | output | 16 | Vector address of the winner |
| irq_mask | output | 1 | Current mask bit |
| wake | output | 1 | Leaving the wait state |
| cpu_run | output | 1 | Processor clock enable |
| boot_fetch | output | 1 | Reset vector fetch cycle |

## Verification
A wrong sequencer state shows at once: a stuck `ST_SLEEP` holds `cpu_run` low and a missed wfi_enter leaves it high one edge after the wait instruction. A corrupted mask bit surfaces as a `take_irq` that appears or fails to appear at the very next boundary with a pending source. A latch that sets on the wrong edge or at the wrong cycle is visible on `reg_rdata` within three clocks of the pin change, and a misordered rank shows as a wrong `vec_addr` in the cycle the competing sources are live.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NUM_PERIPH = 8;
    localparam int NUM_EXT    = 2;
    localparam int NUM_SRC    = NUM_PERIPH + NUM_EXT + 1;
    localparam int VEC_W      = 16;
    localparam int REG_W      = 2 * NUM_EXT;
    localparam int EN_BASE    = 0;
    localparam int LAT_BASE   = NUM_EXT;
    localparam logic [VEC_W-1:0] RESET_VEC = 16'hFFFE;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } seq_state_t;

    // Rank 0 is the highest priority.
    function automatic logic [VEC_W-1:0] src_vector(input int rank);
        logic [VEC_W-1:0] v;
        case (rank)
            0:       v = 16'hFFFC;
            1:       v = 16'hFFFA;
            2:       v = 16'hFFF6;
            3:       v = 16'hFFEE;
            4:       v = 16'hFFEC;
            5:       v = 16'hFFEA;
            6:       v = 16'hFFE8;
            7:       v = 16'hFFE6;
            8:       v = 16'hFFE4;
            9:       v = 16'hFFE2;
            10:      v = 16'hFFE0;
            default: v = RESET_VEC;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/intc_edge_latch.sv
module intc_edge_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic wr_clr,
    output logic lat
);
    logic [SYNC_STAGES:0] smp_q;
    logic                 fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '1;
        end else begin
            smp_q <= {smp_q[SYNC_STAGES-1:0], pin};
        end
    end

    assign fall = smp_q[SYNC_STAGES] & ~smp_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat <= 1'b0;
        end else begin
            lat <= fall | (lat & ~wr_clr);
        end
    end

    // R1: a detected falling edge is held in the latch
    assert_fall_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> lat);
    // R2: a clear with no edge empties the latch
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !fall) |=> !lat);
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_p,
    input  logic [N-1:0] clr_p,
    output logic [N-1:0] pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend | set_p) & ~clr_p;
        end
    end

    // R4: a flag-clear pulse always empties the pending bit
    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_p) |=> ((pend & $past(clr_p)) == '0));
endmodule

// File: rtl/intc_rank.sv
module intc_rank
    import intc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [VEC_W-1:0] vec
);
    always_comb begin
        any = 1'b0;
        vec = RESET_VEC;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                vec = src_vector(i);
            end
        end
    end
endmodule

// File: rtl/intc_seq.sv
module intc_seq
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic insn_end,
    input  logic wfi_exec,
    input  logic iret_exec,
    input  logic stacked_i,
    input  logic mask_set,
    input  logic mask_clr,
    input  logic cand_any,
    output logic take,
    output logic wake,
    output logic cpu_run,
    output logic boot_fetch,
    output logic irq_mask
);
    seq_state_t state_q, state_d;
    logic       mask_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_BOOT;
            irq_mask <= 1'b1;
        end else begin
            state_q  <= state_d;
            irq_mask <= mask_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        take       = 1'b0;
        wake       = 1'b0;
        cpu_run    = 1'b1;
        boot_fetch = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                boot_fetch = 1'b1;
                state_d    = ST_RUN;
            end
            ST_RUN: begin
                take = insn_end & cand_any;
                if (wfi_exec && !take) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                cpu_run = 1'b0;
                take    = cand_any;
                wake    = cand_any;
                if (cand_any) state_d = ST_RUN;
            end
            default: state_d = ST_BOOT;
        endcase

        if (take)                               mask_d = 1'b1;
        else if (iret_exec)                     mask_d = stacked_i;
        else if (state_q == ST_RUN && wfi_exec) mask_d = 1'b0;
        else if (mask_set)                      mask_d = 1'b1;
        else if (mask_clr)                      mask_d = 1'b0;
        else                                    mask_d = irq_mask;
    end

    // R5: entry only at an instruction boundary while running
    assert_take_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cpu_run) |-> insn_end);
    // R8: entering a handler masks further requests
    assert_mask_on_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> irq_mask);
    // R9: return restores the stacked mask bit
    assert_iret_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_exec && !take) |=> (irq_mask == $past(stacked_i)));
    // R10: wait instruction unmasks and gates the processor clock
    assert_wfi_unmask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wfi_exec && !take && !iret_exec) |=> (!irq_mask && !cpu_run));
endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EXT-1:0]    ext_pin,
    input  logic [NUM_PERIPH-1:0] periph_set,
    input  logic [NUM_PERIPH-1:0] periph_clr,
    input  logic [NUM_PERIPH-1:0] periph_en,
    input  logic                  trap_req,
    input  logic                  insn_end,
    input  logic                  wfi_exec,
    input  logic                  iret_exec,
    input  logic                  stacked_i,
    input  logic                  mask_set,
    input  logic                  mask_clr,
    input  logic                  reg_we,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  take_irq,
    output logic [VEC_W-1:0]      vec_addr,
    output logic                  irq_mask,
    output logic                  wake,
    output logic                  cpu_run,
    output logic                  boot_fetch
);
    logic [NUM_EXT-1:0]    en_q;
    logic [NUM_EXT-1:0]    lat;
    logic [NUM_PERIPH-1:0] pend;
    logic [NUM_PERIPH-1:0] p_req;
    logic [NUM_EXT-1:0]    e_req;
    logic                  trap_c;
    logic [NUM_SRC-1:0]    src;
    logic                  cand_any;
    logic [VEC_W-1:0]      rank_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (reg_we) begin
            en_q <= reg_wdata[EN_BASE +: NUM_EXT];
        end
    end

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_edge
        intc_edge_latch #(.SYNC_STAGES(2)) i_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (ext_pin[g]),
            .wr_clr (reg_we & ~reg_wdata[LAT_BASE + g]),
            .lat    (lat[g])
        );
    end

    intc_pending #(.N(NUM_PERIPH)) i_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_p (periph_set),
        .clr_p (periph_clr),
        .pend  (pend)
    );

    assign reg_rdata = {lat, en_q};

    assign p_req  = pend & periph_en & {NUM_PERIPH{~irq_mask}};
    assign e_req  = lat & en_q & {NUM_EXT{~irq_mask}};
    assign trap_c = trap_req & cpu_run;

    // Sources in rank order, rank 0 first.
    assign src = {p_req[7], p_req[6], p_req[5], e_req[0], e_req[1],
                  p_req[4], p_req[3], trap_c, p_req[2], p_req[1], p_req[0]};

    intc_rank #(.N(NUM_SRC)) i_rank (
        .req (src),
        .any (cand_any),
        .vec (rank_vec)
    );

    intc_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_end   (insn_end),
        .wfi_exec   (wfi_exec),
        .iret_exec  (iret_exec),
        .stacked_i  (stacked_i),
        .mask_set   (mask_set),
        .mask_clr   (mask_clr),
        .cand_any   (cand_any),
        .take       (take_irq),
        .wake       (wake),
        .cpu_run    (cpu_run),
        .boot_fetch (boot_fetch),
        .irq_mask   (irq_mask)
    );

    assign vec_addr = rank_vec;

    // R6: with the mask set, only the trap may be taken
    assert_trap_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && irq_mask) |-> (trap_req && vec_addr == 16'hFFEE));
    // R7: the top-ranked peripheral always wins when unmasked
    assert_top_rank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !irq_mask && pend[0] && periph_en[0]) |-> (vec_addr == 16'hFFFC));
    // R3: a disabled edge source alone never causes entry
    assert_edge_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !trap_req && ((pend & periph_en) == '0) && ((lat & en_q) == '0)) |-> 1'b0);
endmodule

// File: tb/test_intc_core.sv
module test_intc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_pin = 2'b11;
    logic [7:0]  periph_set = '0, periph_clr = '0, periph_en = '0;
    logic        trap_req = 0, insn_end = 0, wfi_exec = 0, iret_exec = 0, stacked_i = 0;
    logic        mask_set = 0, mask_clr = 0, reg_we = 0;
    logic [3:0]  reg_wdata = '0;
    logic [3:0]  reg_rdata;
    logic        take_irq, irq_mask, wake, cpu_run, boot_fetch;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    intc_core i_intc_core (.*);

    // {pend[7:0], edge[1:0], trap, vector}
    localparam logic [26:0] TABLE [12] = '{
        {8'h80, 2'b00, 1'b0, 16'hFFE0},
        {8'h40, 2'b00, 1'b0, 16'hFFE2},
        {8'h20, 2'b00, 1'b0, 16'hFFE4},
        {8'h00, 2'b01, 1'b0, 16'hFFE6},
        {8'h00, 2'b11, 1'b0, 16'hFFE8},
        {8'h20, 2'b10, 1'b0, 16'hFFE8},
        {8'h10, 2'b10, 1'b0, 16'hFFEA},
        {8'h18, 2'b00, 1'b0, 16'hFFEC},
        {8'h08, 2'b00, 1'b1, 16'hFFEE},
        {8'h04, 2'b00, 1'b1, 16'hFFF6},
        {8'h06, 2'b00, 1'b0, 16'hFFFA},
        {8'hFF, 2'b11, 1'b1, 16'hFFFC}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nxt;
        @(negedge clk);
    endtask

    task automatic do_reset;
        rst_n = 0; ext_pin = 2'b11; periph_set = '0; periph_clr = '0; periph_en = '0;
        trap_req = 0; insn_end = 0; wfi_exec = 0; iret_exec = 0; mask_set = 0;
        mask_clr = 0; reg_we = 0;
        repeat (2) nxt;
        rst_n = 1;
    endtask

    task automatic pin_fall(input int idx);
        ext_pin[idx] = 1'b0;
        repeat (4) nxt;
        ext_pin[idx] = 1'b1;
        repeat (4) nxt;
    endtask

    task automatic wr(input logic [3:0] d);
        reg_we = 1; reg_wdata = d;
        nxt;
        reg_we = 0;
    endtask

    task automatic pulse_clr_mask;
        mask_clr = 1; nxt; mask_clr = 0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11 reset state
        do_reset;
        #1;
        check("R11 boot_fetch first cycle", boot_fetch, 1);
        check("R11 mask", irq_mask, 1);
        check("R11 rdata", reg_rdata, 0);
        check("R11 cpu_run", cpu_run, 1);
        check("R11 take", take_irq, 0);
        check("R7 idle vector", vec_addr, 16'hFFFE);
        nxt; #1;
        check("R11 boot_fetch ends", boot_fetch, 0);

        // R7 rank table
        foreach (TABLE[k]) begin
            do_reset;
            nxt;
            wr({2'b00, TABLE[k][18:17]});
            if (TABLE[k][17]) pin_fall(0);
            if (TABLE[k][18]) pin_fall(1);
            periph_en = 8'hFF; periph_set = TABLE[k][26:19];
            nxt;
            periph_set = '0;
            pulse_clr_mask;
            trap_req = TABLE[k][16]; insn_end = 1;
            #1;
            check("R7 table take", take_irq, 1);
            check("R7 table vector", vec_addr, TABLE[k][15:0]);
            nxt;
            insn_end = 0; trap_req = 0;
        end

        // R1 edge timing
        do_reset; nxt;
        ext_pin[0] = 0;
        nxt; nxt; #1;
        check("R1 latch not yet", reg_rdata[2], 0);
        nxt; #1;
        check("R1 latch set on third edge", reg_rdata[2], 1);
        check("R1 other latch untouched", reg_rdata[3], 0);
        ext_pin[0] = 1;
        repeat (4) nxt;

        // R2 register behaviour
        wr(4'b0011); #1;
        check("R2 write 0 clears latch, enables written", reg_rdata, 4'b0011);
        wr(4'b1111); #1;
        check("R2 write 1 ignored on latch", reg_rdata, 4'b0011);
        ext_pin[1] = 0; repeat (4) nxt;
        wr(4'b0011);
        ext_pin[1] = 1; repeat (4) nxt; #1;
        check("R1 rising edge sets nothing", reg_rdata[3], 0);

        // R3 masked edge request
        pin_fall(0);
        insn_end = 1; #1;
        check("R3 masked no take", take_irq, 0);
        nxt; insn_end = 0;
        pulse_clr_mask;
        insn_end = 1; #1;
        check("R3 unmasked take", take_irq, 1);
        check("R3 vector pin 0", vec_addr, 16'hFFE6);
        nxt; insn_end = 0; #1;
        check("R8 mask after entry", irq_mask, 1);
        wr(4'b0100);
        pulse_clr_mask;
        insn_end = 1; #1;
        check("R3 disabled no take", take_irq, 0);
        check("R3 latch kept", reg_rdata, 4'b0100);
        insn_end = 0;

        // R5 boundary only
        wr(4'b0101); #1;
        check("R5 no take off boundary", take_irq, 0);
        insn_end = 1; #1;
        check("R5 take on boundary", take_irq, 1);
        nxt; insn_end = 0;

        // R6 trap ignores mask
        #1;
        check("R6 mask set", irq_mask, 1);
        trap_req = 1; insn_end = 1; #1;
        check("R6 trap taken", take_irq, 1);
        check("R6 trap vector", vec_addr, 16'hFFEE);
        nxt; trap_req = 0; insn_end = 0;

        // R9 return restores mask
        iret_exec = 1; stacked_i = 0; nxt; iret_exec = 0; #1;
        check("R9 restore 0", irq_mask, 0);
        iret_exec = 1; stacked_i = 1; nxt; iret_exec = 0; #1;
        check("R9 restore 1", irq_mask, 1);

        // R12 software mask
        mask_clr = 1; nxt; mask_clr = 0; #1;
        check("R12 mask clear", irq_mask, 0);
        mask_set = 1; nxt; mask_set = 0; #1;
        check("R12 mask set", irq_mask, 1);

        // R4 peripheral pending
        do_reset; nxt;
        periph_set = 8'h80; nxt; periph_set = '0;
        pulse_clr_mask;
        insn_end = 1; #1;
        check("R4 pending disabled", take_irq, 0);
        periph_en = 8'h80; #1;
        check("R4 pending enabled", take_irq, 1);
        check("R4 vector", vec_addr, 16'hFFE0);
        insn_end = 0; periph_en = 0;
        periph_clr = 8'h80; nxt; periph_clr = 0;
        periph_en = 8'h80; insn_end = 1; #1;
        check("R4 cleared request lost", take_irq, 0);
        insn_end = 0;

        // R10 wait state
        periph_en = 8'hFF;
        mask_set = 1; nxt; mask_set = 0;
        wfi_exec = 1; nxt; wfi_exec = 0; #1;
        check("R10 mask cleared", irq_mask, 0);
        check("R10 cpu stopped", cpu_run, 0);
        check("R10 no wake idle", wake, 0);
        nxt; #1;
        check("R10 still asleep", cpu_run, 0);
        periph_set = 8'h40; nxt; periph_set = 0; #1;
        check("R10 wake", wake, 1);
        check("R10 take on wake", take_irq, 1);
        check("R10 wake vector", vec_addr, 16'hFFE2);
        nxt; #1;
        check("R10 cpu running", cpu_run, 1);
        check("R10 masked after wake", irq_mask, 1);
        check("R10 wake ends", wake, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule